// File: doc/BRIEF.md
# DMA Source Chain Tag Walker

This block computes the register updates for a chained DMA source channel each time a 128-bit chain tag has been decoded. From the tag type in the channel control word, the quadword count carried by the tag, and the channel's current tag-pointer and data-pointer addresses, it produces the next tag-pointer and data-pointer values. It also raises a flag when the chain must stop.

Call and return tags use a small return-address stack that the block keeps itself, two entries deep by default. A call stores the address just past its own data and jumps to a new tag. A return resumes at the most recently stored address. Overflow and underflow of this stack stop the chain, as does any tag the channel does not support.

The next addresses and the stop flag are combinational. Stack changes take effect only on the clock edge where the single-cycle update strobe is high. The surrounding channel logic decides when to write the two next addresses back into its own registers. Fetching tags and moving data are done elsewhere.

Top module: `tw_chain_walker`

## Requirements
- R1: The tag type is read from bits 14:12 of `ctrl`, coded 0 skip-and-stop, 1 count, 2 next, 3 reference, 4 reference-with-stall, 5 call, 6 return, 7 end. No other bit of `ctrl` affects any output.
- R2: Tag 0 gives next tag pointer = current tag pointer + 16 and leaves the data pointer unchanged, with `chain_end` high.
- R3: Tag 1 gives next data pointer = tag pointer + 16 and next tag pointer = tag pointer + 16 + 16×`qwc`, with `chain_end` low.
- R4: Tag 2 gives next data pointer = tag pointer + 16 and next tag pointer = the current data pointer, with `chain_end` low.
- R5: Tags 3 and 4 give next tag pointer = tag pointer + 16 and leave the data pointer unchanged, with `chain_end` low.
- R6: When the stack is enabled, tag 5 with the stack pointer below its depth writes tag pointer + 16 + 16×`qwc` into the slot selected by the pointer, and the pointer increments on the strobe. The outputs are next data pointer = tag pointer + 16, next tag pointer = current data pointer, and `chain_end` low.
- R7: When the stack is enabled, tag 5 with the stack full raises `chain_end`, sets next data pointer = tag pointer + 16, keeps the tag pointer and leaves the stack unchanged.
- R8: When the stack is enabled, tag 6 with a non-empty stack sets next tag pointer to the most recently pushed address and next data pointer = tag pointer + 16. The pointer decrements on the strobe and `chain_end` stays low.
- R9: When the stack is enabled, tag 6 with an empty stack raises `chain_end`, sets next data pointer = tag pointer + 16 and keeps the tag pointer.
- R10: Tag 7 sets next data pointer = tag pointer + 16, keeps the tag pointer and raises `chain_end`.
- R11: With `stk_en` low, tags 5 and 6 raise `chain_end`, keep both pointers unchanged and leave the stack untouched.
- R12: Reset clears the stack pointer to 0. The stack changes only on clock edges where `upd` is high.
- R13: All address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Single-cycle strobe committing the stack change of the current tag |
| ctrl | input | CW | Channel control word; bits 14:12 hold the tag type |
| stk_en | input | 1 | Channel supports call/return tags |
| qwc | input | QW | Quadword count of the current tag |
| cur_taddr | input | AW | Current tag pointer |
| cur_maddr | input | AW | Current data pointer (holds the tag's address field) |
| nxt_taddr | output | AW | Next tag pointer |
| nxt_maddr | output | AW | Next data pointer |
| chain_end | output | 1 | Chain stops after this tag |
| stk_ptr | output | $clog2(DEPTH+1) | Return-address stack occupancy |

## Verification
The bench builds the walker with 12-bit addresses, a 4-bit count and the default two-entry stack. This keeps address wrap within easy reach, so a tag near the top of the space rolls over in a single step. It sweeps every tag type against every stack occupancy (empty, one, full) with the stack enabled and disabled. A long stream of mixed tags, with the strobe sometimes withheld, follows the sweep. Together these reach every overflow, underflow and stale-slot ordering the two-entry stack can take.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Tag type coding carried in the channel control word
    typedef enum logic [2:0] {
        TG_REFE = 3'd0,
        TG_CNT  = 3'd1,
        TG_NEXT = 3'd2,
        TG_REF  = 3'd3,
        TG_REFS = 3'd4,
        TG_CALL = 3'd5,
        TG_RET  = 3'd6,
        TG_END  = 3'd7
    } tag_e;

    localparam int TAG_LSB  = 12;
    localparam int TAG_W    = 3;
    localparam int QW_BYTES = 16;
    localparam int QW_SHIFT = 4;

    // Address-update behaviour selected for one tag
    typedef enum logic [2:0] {
        ST_SKIP_STOP,  // tag pointer steps, chain stops
        ST_COUNT,      // data follows the tag, next tag follows the data
        ST_JUMP,       // data follows the tag, next tag from address field
        ST_SKIP,       // tag pointer steps, data from address field
        ST_CALL,       // push return address, jump
        ST_RET,        // pop return address
        ST_STOP,       // data follows the tag, chain stops
        ST_BAD         // unsupported: everything held, chain stops
    } step_e;

    function automatic step_e step_of(tag_e tag, logic stack_ok);
        step_e s;
        unique case (tag)
            TG_REFE: s = ST_SKIP_STOP;
            TG_CNT:  s = ST_COUNT;
            TG_NEXT: s = ST_JUMP;
            TG_REF,
            TG_REFS: s = ST_SKIP;
            TG_CALL: s = stack_ok ? ST_CALL : ST_BAD;
            TG_RET:  s = stack_ok ? ST_RET  : ST_BAD;
            default: s = ST_STOP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tw_decode.sv
module tw_decode
    import tw_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic [CW-1:0] ctrl,
    input  logic          stk_en,
    output step_e         step
);
    tag_e tag;
    logic unused_ctrl_bits;

    assign tag  = tag_e'(ctrl[TAG_LSB +: TAG_W]);
    assign step = step_of(tag, stk_en);

    assign unused_ctrl_bits = ^{ctrl[CW-1:TAG_LSB+TAG_W], ctrl[TAG_LSB-1:0]};
endmodule

// File: rtl/tw_stack.sv
module tw_stack #(
    parameter int AW    = 32,
    parameter int DEPTH = 2,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [PW-1:0] ptr,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] top
);
    logic [AW-1:0] slot_q [DEPTH];
    logic          do_push;
    logic          do_pop;

    assign do_push = upd && push && !full;
    assign do_pop  = upd && pop && !empty;
    assign full    = (ptr >= PW'(DEPTH));
    assign empty   = (ptr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (do_push) begin
            ptr <= ptr + 1'b1;
        end else if (do_pop) begin
            ptr <= ptr - 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (do_push && ptr == PW'(i)) begin
                slot_q[i] <= push_val;
            end else if (do_pop && ptr == PW'(i + 1)) begin
                slot_q[i] <= '0;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr == PW'(i + 1)) top = slot_q[i];
        end
    end
endmodule

// File: rtl/tw_addr.sv
module tw_addr
    import tw_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input  step_e         step,
    input  logic [AW-1:0] cur_t,
    input  logic [AW-1:0] cur_m,
    input  logic [QW-1:0] qwc,
    input  logic          full,
    input  logic          empty,
    input  logic [AW-1:0] top,
    output logic [AW-1:0] nxt_t,
    output logic [AW-1:0] nxt_m,
    output logic          fin,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] push_val
);
    logic [AW-1:0] t_step;
    logic [AW-1:0] span;
    logic [AW-1:0] past_data;

    assign t_step    = cur_t + AW'(QW_BYTES);
    assign span      = AW'(qwc) << QW_SHIFT;
    assign past_data = t_step + span;
    assign push_val  = past_data;

    always_comb begin
        nxt_t = cur_t;
        nxt_m = cur_m;
        fin   = 1'b0;
        push  = 1'b0;
        pop   = 1'b0;
        unique case (step)
            ST_SKIP_STOP: begin
                nxt_t = t_step;
                fin   = 1'b1;
            end
            ST_COUNT: begin
                nxt_m = t_step;
                nxt_t = past_data;
            end
            ST_JUMP: begin
                nxt_m = t_step;
                nxt_t = cur_m;
            end
            ST_SKIP: begin
                nxt_t = t_step;
            end
            ST_CALL: begin
                nxt_m = t_step;
                if (full) begin
                    fin = 1'b1;
                end else begin
                    push  = 1'b1;
                    nxt_t = cur_m;
                end
            end
            ST_RET: begin
                nxt_m = t_step;
                if (empty) begin
                    fin = 1'b1;
                end else begin
                    pop   = 1'b1;
                    nxt_t = top;
                end
            end
            ST_STOP: begin
                nxt_m = t_step;
                fin   = 1'b1;
            end
            default: begin
                fin = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tw_chain_walker.sv
module tw_chain_walker
    import tw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int QW    = 16,
    parameter int CW    = 32,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd,
    input  logic [CW-1:0]              ctrl,
    input  logic                       stk_en,
    input  logic [QW-1:0]              qwc,
    input  logic [AW-1:0]              cur_taddr,
    input  logic [AW-1:0]              cur_maddr,
    output logic [AW-1:0]              nxt_taddr,
    output logic [AW-1:0]              nxt_maddr,
    output logic                       chain_end,
    output logic [$clog2(DEPTH+1)-1:0] stk_ptr
);
    step_e         step;
    logic          full;
    logic          empty;
    logic          push;
    logic          pop;
    logic [AW-1:0] top;
    logic [AW-1:0] push_val;

    tw_decode #(.CW(CW)) u_dec (
        .ctrl   (ctrl),
        .stk_en (stk_en),
        .step   (step)
    );

    tw_addr #(.AW(AW), .QW(QW)) u_addr (
        .step     (step),
        .cur_t    (cur_taddr),
        .cur_m    (cur_maddr),
        .qwc      (qwc),
        .full     (full),
        .empty    (empty),
        .top      (top),
        .nxt_t    (nxt_taddr),
        .nxt_m    (nxt_maddr),
        .fin      (chain_end),
        .push     (push),
        .pop      (pop),
        .push_val (push_val)
    );

    tw_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .ptr      (stk_ptr),
        .full     (full),
        .empty    (empty),
        .top      (top)
    );
endmodule

// File: rtl/tw_chain_walker_chk.sv
module tw_chain_walker_chk #(
    parameter int AW    = 32,
    parameter int QW    = 16,
    parameter int CW    = 32,
    parameter int DEPTH = 2,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          upd,
    input logic [CW-1:0] ctrl,
    input logic          stk_en,
    input logic [QW-1:0] qwc,
    input logic [AW-1:0] cur_taddr,
    input logic [AW-1:0] cur_maddr,
    input logic [AW-1:0] nxt_taddr,
    input logic [AW-1:0] nxt_maddr,
    input logic          chain_end,
    input logic [PW-1:0] stk_ptr
);
    logic [2:0] tg;
    logic       unused_chk_bits;

    assign tg = ctrl[14:12];
    assign unused_chk_bits = ^{ctrl[CW-1:15], ctrl[11:0]};

    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (rst)
        stk_ptr <= PW'(DEPTH));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(stk_ptr));

    p_call_push_r6: assert property (@(posedge clk) disable iff (rst)
        (upd && stk_en && tg == 3'd5 && stk_ptr < PW'(DEPTH))
        |=> stk_ptr == PW'($past(stk_ptr) + 1'b1));

    p_ret_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (upd && stk_en && tg == 3'd6 && stk_ptr != '0)
        |=> stk_ptr == PW'($past(stk_ptr) - 1'b1));

    p_disabled_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!stk_en && (tg == 3'd5 || tg == 3'd6))
        |-> (chain_end && nxt_taddr == cur_taddr && nxt_maddr == cur_maddr));

    p_end_tag_r10: assert property (@(posedge clk) disable iff (rst)
        tg == 3'd7 |-> (chain_end && nxt_taddr == cur_taddr));

    p_skip_stop_r2: assert property (@(posedge clk) disable iff (rst)
        tg == 3'd0 |-> (chain_end && nxt_taddr == AW'(cur_taddr + AW'(16))));

    p_count_r3: assert property (@(posedge clk) disable iff (rst)
        tg == 3'd1 |-> (!chain_end &&
            nxt_taddr == AW'(cur_taddr + AW'(16) + (AW'(qwc) << 4))));

    p_ref_cont_r5: assert property (@(posedge clk) disable iff (rst)
        (tg == 3'd3 || tg == 3'd4) |-> (!chain_end && nxt_maddr == cur_maddr));
endmodule

bind tw_chain_walker tw_chain_walker_chk #(
    .AW(AW), .QW(QW), .CW(CW), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd       (upd),
    .ctrl      (ctrl),
    .stk_en    (stk_en),
    .qwc       (qwc),
    .cur_taddr (cur_taddr),
    .cur_maddr (cur_maddr),
    .nxt_taddr (nxt_taddr),
    .nxt_maddr (nxt_maddr),
    .chain_end (chain_end),
    .stk_ptr   (stk_ptr)
);

// File: tb/tb_tw_chain_walker.sv
module tb_tw_chain_walker;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int QW = 4;
    localparam int CW = 16;
    localparam int DEPTH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          upd = 1'b0;
    logic [CW-1:0] ctrl = '0;
    logic          stk_en = 1'b0;
    logic [QW-1:0] qwc = '0;
    logic [AW-1:0] cur_taddr = '0;
    logic [AW-1:0] cur_maddr = '0;
    logic [AW-1:0] nxt_taddr;
    logic [AW-1:0] nxt_maddr;
    logic          chain_end;
    logic [1:0]    stk_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the return stack
    int            m_ptr = 0;
    logic [AW-1:0] m_slot [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_chain_walker #(.AW(AW), .QW(QW), .CW(CW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .upd(upd), .ctrl(ctrl), .stk_en(stk_en),
        .qwc(qwc), .cur_taddr(cur_taddr), .cur_maddr(cur_maddr),
        .nxt_taddr(nxt_taddr), .nxt_maddr(nxt_maddr),
        .chain_end(chain_end), .stk_ptr(stk_ptr)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        upd = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
        m_ptr = 0;
        m_slot[0] = '0;
        m_slot[1] = '0;
        @(negedge clk);
        chk("R12 reset pointer", int'(stk_ptr), 0);
    endtask

    // Apply one tag, compare the combinational outputs, optionally strobe.
    task automatic apply(int tag, bit en, logic [AW-1:0] t, logic [AW-1:0] m,
                         logic [QW-1:0] q, bit strobe, string tag_req);
        logic [AW-1:0] t16, after, et, em;
        logic [CW-1:0] c;
        bit ee, mpush, mpop;
        string req;
        @(negedge clk);
        c = CW'($urandom);                 // R1: noise outside bits 14:12
        c[14:12] = 3'(tag);
        ctrl = c; stk_en = en; cur_taddr = t; cur_maddr = m; qwc = q;
        t16   = t + 12'd16;
        after = t16 + (AW'(q) << 4);
        et = t; em = m; ee = 0; mpush = 0; mpop = 0;
        case (tag)
            0: begin et = t16; ee = 1; req = "R2"; end
            1: begin em = t16; et = after; req = "R3"; end
            2: begin em = t16; et = m; req = "R4"; end
            3, 4: begin et = t16; req = "R5"; end
            5: if (!en) begin ee = 1; req = "R11"; end
               else if (m_ptr >= DEPTH) begin em = t16; ee = 1; req = "R7"; end
               else begin em = t16; et = m; mpush = 1; req = "R6"; end
            6: if (!en) begin ee = 1; req = "R11"; end
               else if (m_ptr == 0) begin em = t16; ee = 1; req = "R9"; end
               else begin em = t16; et = m_slot[m_ptr-1]; mpop = 1; req = "R8"; end
            default: begin em = t16; ee = 1; req = "R10"; end
        endcase
        if (tag_req != "") req = tag_req;
        #1;
        chk({req, " next tag pointer"}, int'(nxt_taddr), int'(et));
        chk({req, " next data pointer"}, int'(nxt_maddr), int'(em));
        chk({req, " chain end"}, int'(chain_end), int'(ee));
        if (strobe) begin
            upd = 1'b1;
            if (mpush) begin m_slot[m_ptr] = after; m_ptr++; end
            if (mpop) begin m_slot[m_ptr-1] = '0; m_ptr--; end
        end
        @(posedge clk);
        #1 upd = 1'b0;
        chk(strobe ? {req, " stack pointer"} : "R12 pointer held without strobe",
            int'(stk_ptr), m_ptr);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R9: empty stack after reset, return stops the chain
        apply(6, 1, 12'h100, 12'h200, 4'h3, 1, "R9");
        // R1: field bits elsewhere in ctrl are random on every apply
        apply(3, 1, 12'h040, 12'h777, 4'h0, 1, "R1");
        // R13: wrap near the top of the address space
        apply(1, 1, 12'hFF8, 12'h000, 4'hF, 1, "R13");
        apply(5, 1, 12'hFF0, 12'h321, 4'h2, 1, "R13");
        apply(6, 1, 12'h010, 12'h000, 4'h0, 1, "R13");

        // Sweep every tag against every stack occupancy, stack on and off
        for (int en = 0; en < 2; en++) begin
            for (int sp = 0; sp <= DEPTH; sp++) begin
                for (int tag = 0; tag < 8; tag++) begin
                    do_reset();
                    for (int k = 0; k < sp; k++)
                        apply(5, 1, AW'($urandom), AW'($urandom), QW'($urandom), 1, "");
                    apply(tag, en[0], AW'($urandom), AW'($urandom), QW'($urandom), 1, "");
                end
            end
        end

        // Mixed stream with occasional withheld strobes (R12)
        do_reset();
        for (int n = 0; n < 1500; n++) begin
            int tg;
            bit s, e;
            tg = int'($urandom % 8);
            s  = ($urandom % 4) != 0;
            e  = ($urandom % 8) != 0;
            if (n % 3 == 0) tg = 5 + int'($urandom % 2);
            apply(tg, e, AW'($urandom), AW'($urandom), QW'($urandom), s, "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule